// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a virtual address into a physical one through a small register-held table of segment descriptors. The upper bits of the virtual address pick a descriptor. The lower bits are an offset inside that segment. Each descriptor behaves as its own base-and-limit pair. It also carries a rights class that names the single kind of access the segment accepts: none, read, write or execute. A request gives the address and the access kind. One cycle later the block answers with a physical address or with a fault cause. When it reports a fault, it issues no address.

Privileged software fills the table through a write port. On a context switch it can wipe every descriptor's rights in one cycle. A write or wipe that arrives while the privileged-mode input is low leaves the table untouched and raises a one-cycle denial flag.

The response side is a three-state machine clocked every cycle. ST_IDLE means no response is being presented. ST_GRANT presents a translated address. ST_FAULT presents a fault cause. From any state, the next state is ST_IDLE when no request is valid. It is ST_FAULT when the checked request breaks its bound or its rights. Otherwise it is ST_GRANT.

Top module: `seg_xlate_top`

## Requirements
- R1: The segment number is bits 15:13 of the 16-bit virtual address, and the offset is bits 12:0.
- R2: A valid request with no fault gives rsp_valid high on the next clock edge, with rsp_fault 2'b00 and rsp_paddr equal to the descriptor base plus the zero-extended offset, taken modulo 2^20.
- R3: An offset strictly greater than the descriptor size gives rsp_fault 2'b01 with rsp_paddr 0. An offset equal to the size is allowed.
- R4: Rights codes are 2'b00 none, 2'b01 read, 2'b10 write and 2'b11 execute, and access codes are 2'b01 read, 2'b10 write and 2'b11 execute. An in-bound request is granted only when the rights are not none and equal the access code. Otherwise it gives rsp_fault 2'b10 with rsp_paddr 0.
- R5: When both the bound and the rights are violated, rsp_fault is 2'b01.
- R6: After reset every descriptor has rights none, size 0 and base 0, and rsp_valid and cfg_denied are low.
- R7: A privileged descriptor write takes effect for requests on later edges. A request in the same cycle as the write is translated with the old descriptor.
- R8: A descriptor write or clear made with cfg_priv low changes no descriptor, and cfg_denied is high for exactly the next cycle.
- R9: A privileged clear sets the rights of every descriptor to none. If a privileged write comes in the same cycle, the written segment takes the new descriptor.
- R10: A cycle with no valid request gives rsp_valid low on the next edge, with rsp_fault and rsp_paddr zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 16 | Virtual address: segment and offset |
| req_acc | input | 2 | Access kind: 01 read, 10 write, 11 execute |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_paddr | output | 20 | Translated physical address, zero on fault |
| rsp_fault | output | 2 | Fault cause: 00 none, 01 bound, 10 rights |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_clr | input | 1 | Context-switch wipe of all rights |
| cfg_priv | input | 1 | Privileged mode, gates writes and wipes |
| cfg_seg | input | 3 | Segment selected for a write |
| cfg_base | input | 20 | Base to be written |
| cfg_size | input | 13 | Largest legal offset to be written |
| cfg_rights | input | 2 | Rights class to be written |
| cfg_denied | output | 1 | Pulse after a write or wipe without privilege |

## Verification
A descriptor update and a translation can fall in the same cycle, and so can a wipe and a write. The bench drives a write to segment 0 with a new base in the same cycle as a read request to segment 0. It expects the old base in the response and the new base on the next request. It also drives a privileged wipe together with a write to segment 2. It then expects segment 0 to fault on rights while segment 2 still translates.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        RT_NONE  = 2'b00,
        RT_READ  = 2'b01,
        RT_WRITE = 2'b10,
        RT_EXEC  = 2'b11
    } rights_t;

    typedef enum logic [1:0] {
        FC_OK    = 2'b00,
        FC_BOUND = 2'b01,
        FC_PERM  = 2'b10
    } fault_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GRANT = 2'b01,
        ST_FAULT = 2'b10
    } xl_state_t;

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 13,
    parameter int PA_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             clr,
    input  logic             priv,
    input  logic [SEG_W-1:0] wseg,
    input  logic [PA_W-1:0]  wbase,
    input  logic [OFF_W-1:0] wsize,
    input  rights_t          wrights,
    input  logic [SEG_W-1:0] rseg,
    output logic [PA_W-1:0]  rbase,
    output logic [OFF_W-1:0] rsize,
    output rights_t          rrights,
    output logic             denied
);
    localparam int SEGS = 1 << SEG_W;

    logic [PA_W-1:0]  base_q   [SEGS];
    logic [OFF_W-1:0] size_q   [SEGS];
    rights_t          rights_q [SEGS];
    logic             denied_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SEGS; i++) begin
                base_q[i]   <= '0;
                size_q[i]   <= '0;
                rights_q[i] <= RT_NONE;
            end
        end else if (priv) begin
            for (int i = 0; i < SEGS; i++) begin
                if (we && (wseg == SEG_W'(i))) begin
                    base_q[i]   <= wbase;
                    size_q[i]   <= wsize;
                    rights_q[i] <= wrights;
                end else if (clr) begin
                    rights_q[i] <= RT_NONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) denied_q <= 1'b0;
        else        denied_q <= (we || clr) && !priv;
    end

    assign rbase   = base_q[rseg];
    assign rsize   = size_q[rseg];
    assign rrights = rights_q[rseg];
    assign denied  = denied_q;

    generate
        for (genvar g = 0; g < SEGS; g++) begin : g_entry_chk
            // R8
            user_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !priv |=> (rights_q[g] == $past(rights_q[g])) && (base_q[g] == $past(base_q[g])));
            // R9
            wipe_clears_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (priv && clr && !(we && wseg == SEG_W'(g))) |=> rights_q[g] == RT_NONE);
        end
    endgenerate

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 13,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W+OFF_W-1:0] vaddr,
    input  logic [1:0]             acc,
    input  logic [PA_W-1:0]        base,
    input  logic [OFF_W-1:0]       size,
    input  rights_t                rights,
    output logic [SEG_W-1:0]       seg,
    output logic [PA_W-1:0]        paddr,
    output fault_t                 cause
);
    localparam int VA_W = SEG_W + OFF_W;

    logic [OFF_W-1:0] offset;
    logic             over_bound;
    logic             allowed;

    assign seg    = vaddr[VA_W-1:OFF_W];
    assign offset = vaddr[OFF_W-1:0];

    always_comb begin
        over_bound = offset > size;
        allowed    = (rights != RT_NONE) && (rights == rights_t'(acc));
        paddr      = base + PA_W'(offset);
        if (over_bound)    cause = FC_BOUND;
        else if (!allowed) cause = FC_PERM;
        else               cause = FC_OK;
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 13,
    parameter int PA_W  = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [SEG_W+OFF_W-1:0] req_vaddr,
    input  logic [1:0]             req_acc,
    output logic                   rsp_valid,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [1:0]             rsp_fault,
    input  logic                   cfg_we,
    input  logic                   cfg_clr,
    input  logic                   cfg_priv,
    input  logic [SEG_W-1:0]       cfg_seg,
    input  logic [PA_W-1:0]        cfg_base,
    input  logic [OFF_W-1:0]       cfg_size,
    input  logic [1:0]             cfg_rights,
    output logic                   cfg_denied
);
    logic [SEG_W-1:0] look_seg;
    logic [PA_W-1:0]  tbl_base;
    logic [OFF_W-1:0] tbl_size;
    rights_t          tbl_rights;
    logic [PA_W-1:0]  calc_paddr;
    fault_t           calc_cause;

    xl_state_t        state_q, state_d;
    logic [PA_W-1:0]  paddr_q;
    fault_t           cause_q;

    seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .clr     (cfg_clr),
        .priv    (cfg_priv),
        .wseg    (cfg_seg),
        .wbase   (cfg_base),
        .wsize   (cfg_size),
        .wrights (rights_t'(cfg_rights)),
        .rseg    (look_seg),
        .rbase   (tbl_base),
        .rsize   (tbl_size),
        .rrights (tbl_rights),
        .denied  (cfg_denied)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) check_i (
        .vaddr  (req_vaddr),
        .acc    (req_acc),
        .base   (tbl_base),
        .size   (tbl_size),
        .rights (tbl_rights),
        .seg    (look_seg),
        .paddr  (calc_paddr),
        .cause  (calc_cause)
    );

    always_comb begin
        if (!req_valid)              state_d = ST_IDLE;
        else if (calc_cause != FC_OK) state_d = ST_FAULT;
        else                          state_d = ST_GRANT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            paddr_q <= '0;
            cause_q <= FC_OK;
        end else begin
            state_q <= state_d;
            paddr_q <= calc_paddr;
            cause_q <= calc_cause;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_paddr = '0;
        rsp_fault = FC_OK;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: begin
                rsp_valid = 1'b1;
                rsp_paddr = paddr_q;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = cause_q;
            end
            default:  ;
        endcase
    end

    // R2
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && rsp_fault == 2'b00 && rsp_paddr == '0);
    // R3
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'b00) |-> (rsp_paddr == '0) && $onehot0(rsp_fault));
    // R5
    bound_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[OFF_W-1:0] > tbl_size) |=> rsp_fault == 2'b01);
    // R8
    denied_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_we || cfg_clr) && !cfg_priv) |=> cfg_denied);

endmodule

// File: tb/seg_xlate_top_tb.sv
`timescale 1ns/1ps
module seg_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [19:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        cfg_we = 1'b0, cfg_clr = 1'b0, cfg_priv = 1'b0;
    logic [2:0]  cfg_seg = '0;
    logic [19:0] cfg_base = '0;
    logic [12:0] cfg_size = '0;
    logic [1:0]  cfg_rights = '0;
    logic        cfg_denied;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    seg_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .cfg_we(cfg_we), .cfg_clr(cfg_clr),
        .cfg_priv(cfg_priv), .cfg_seg(cfg_seg), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_rights(cfg_rights), .cfg_denied(cfg_denied)
    );

    // {vaddr, access, expected fault, expected paddr}
    localparam logic [39:0] VEC [13] = '{
        {16'h0010, 2'b01, 2'b00, 20'h10010}, // R1 R2 seg0 read
        {16'h00FF, 2'b01, 2'b00, 20'h100FF}, // R3 offset == size
        {16'h0100, 2'b01, 2'b01, 20'h00000}, // R3 offset > size
        {16'h0010, 2'b10, 2'b10, 20'h00000}, // R4 write to read seg
        {16'h0100, 2'b10, 2'b01, 20'h00000}, // R5 both violated
        {16'h2020, 2'b10, 2'b00, 20'h00010}, // R2 wrap mod 2^20
        {16'h3FFF, 2'b10, 2'b00, 20'h01FEF}, // R1 max offset seg1
        {16'h2020, 2'b01, 2'b10, 20'h00000}, // R4 read of write seg
        {16'h4005, 2'b11, 2'b00, 20'h00405}, // R4 exec seg2
        {16'h4011, 2'b11, 2'b01, 20'h00000}, // R3 seg2 bound
        {16'h6000, 2'b01, 2'b10, 20'h00000}, // R4 unloaded seg3
        {16'h4005, 2'b00, 2'b10, 20'h00000}, // R4 access code 00
        {16'hFFFF, 2'b11, 2'b01, 20'h00000}  // R5 unloaded seg7 bound
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic pv, input logic we, input logic cl, input logic [2:0] sg,
                       input logic [19:0] bs, input logic [12:0] sz, input logic [1:0] rt);
        @(negedge clk);
        cfg_priv = pv; cfg_we = we; cfg_clr = cl; cfg_seg = sg;
        cfg_base = bs; cfg_size = sz; cfg_rights = rt;
        @(negedge clk);
        cfg_we = 1'b0; cfg_clr = 1'b0; cfg_priv = 1'b0;
    endtask

    task automatic xl(input string tag, input logic [15:0] va, input logic [1:0] ac,
                      input logic [1:0] ef, input logic [19:0] ep);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = ac;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(ef));
        chk({tag, " paddr"}, 32'(rsp_paddr), 32'(ep));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk("R6 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R6 cfg_denied", 32'(cfg_denied), 32'd0);
        xl("R6 unloaded seg0", 16'h0000, 2'b01, 2'b10, 20'h0);

        cfg(1'b1, 1'b1, 1'b0, 3'd0, 20'h10000, 13'h00FF, 2'b01);
        cfg(1'b1, 1'b1, 1'b0, 3'd1, 20'hFFFF0, 13'h1FFF, 2'b10);
        cfg(1'b1, 1'b1, 1'b0, 3'd2, 20'h00400, 13'h0010, 2'b11);

        for (int k = 0; k < 13; k++) begin
            xl($sformatf("vec%0d", k), VEC[k][39:24], VEC[k][23:22], VEC[k][21:20], VEC[k][19:0]);
        end

        // R10 idle cycle
        @(negedge clk);
        chk("R10 idle valid", 32'(rsp_valid), 32'd0);
        chk("R10 idle fault", 32'(rsp_fault), 32'd0);
        chk("R10 idle paddr", 32'(rsp_paddr), 32'd0);

        // R7 write and request in the same cycle
        @(negedge clk);
        cfg_priv = 1'b1; cfg_we = 1'b1; cfg_seg = 3'd0;
        cfg_base = 20'h20000; cfg_size = 13'h00FF; cfg_rights = 2'b01;
        req_valid = 1'b1; req_vaddr = 16'h0010; req_acc = 2'b01;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
        chk("R7 same-cycle old base", 32'(rsp_paddr), 32'h10010);
        xl("R7 new base", 16'h0010, 2'b01, 2'b00, 20'h20010);

        // R8 user-mode write ignored
        cfg(1'b0, 1'b1, 1'b0, 3'd2, 20'h55555, 13'h0000, 2'b00);
        chk("R8 denied pulse", 32'(cfg_denied), 32'd1);
        xl("R8 seg2 unchanged", 16'h4005, 2'b11, 2'b00, 20'h00405);
        chk("R8 denied drops", 32'(cfg_denied), 32'd0);
        // R8 user-mode clear ignored
        cfg(1'b0, 1'b0, 1'b1, 3'd0, 20'h0, 13'h0, 2'b00);
        chk("R8 clear denied", 32'(cfg_denied), 32'd1);
        xl("R8 seg1 kept", 16'h2020, 2'b10, 2'b00, 20'h00010);

        // R9 privileged clear together with a write to seg2
        cfg(1'b1, 1'b1, 1'b1, 3'd2, 20'h00400, 13'h0010, 2'b11);
        chk("R9 no denial", 32'(cfg_denied), 32'd0);
        xl("R9 seg0 wiped", 16'h0010, 2'b01, 2'b10, 20'h0);
        xl("R9 seg1 wiped", 16'h2020, 2'b10, 2'b10, 20'h0);
        xl("R9 seg2 rewritten", 16'h4005, 2'b11, 2'b00, 20'h00405);

        finish_run();
    end

endmodule